// File: doc/BRIEF.md
# Timer Tick Source with Shared Prescalers and Per-Channel Dividers

This block turns one base clock into five independent tick-enable strobes for a bank of PWM channel counters. Two 8-bit prescalers each divide the base clock by their setting plus one. The first prescaler serves the low channel group (channels 0 and 1), and the second serves the high group (channels 2, 3 and 4). Behind its group's prescaler, each channel applies its own power-of-two divider. A channel can also take its ticks from an external tick input that belongs to its group. Everything runs in the base clock domain. External inputs are brought in through a two-flop synchronizer and an edge detector.

Configuration arrives as two 32-bit words, held in registers outside this block. The scale word holds both prescaler settings. The route word holds one 4-bit code per channel. A code k that is not in the external-code mask selects division by 2^(k+DIV_BASE). A code that is in the mask selects the group's external input. A new prescaler setting is loaded only when the running prescaler count wraps, so a change never produces a shortened prescaler period.

Each channel has a two-state source machine. In state SRC_DIVIDE, the channel emits a tick when its group prescaler wraps and the low exponent bits of its divide counter are all ones. In state SRC_EXTERNAL, it emits a tick for each synchronized rising edge of its group's external input. The machine moves from SRC_DIVIDE to SRC_EXTERNAL when the channel's code enters the mask, and moves back when the code leaves it. Any change of the code clears the divide counter, so the division restarts.

Top module: `pwm_tick_source`

## Requirements
- R1: While rst_n is low, every bit of tick_en_o is 0.
- R2: Channels 0 and 1 are timed by the prescaler setting in cfg_scale_i[7:0]. Channels 2, 3 and 4 are timed by the setting in cfg_scale_i[15:8].
- R3: With prescaler setting P and a non-external code k, a channel's steady-state distance between ticks is (P+1)·2^(k+DIV_BASE) base clock cycles. With the default DIV_BASE of 1, code 0 divides by 2.
- R4: Channel c reads its code from cfg_route_i[4c+3:4c]. The codes held by the other channels do not affect channel c's tick spacing.
- R5: A prescaler setting written in mid-period takes effect only after the current period ends. If the setting changes from 9 to 2 in the cycle after a tick of a channel using code 0, the next two intervals are 13 and then 6 cycles.
- R6: A code in EXT_MASK selects an external source. With the default mask, only code 4 is external. Channels 0 and 1 follow ext_tick_i[0]; channels 2 to 4 follow ext_tick_i[1]. The other input has no effect on the channel.
- R7: In external mode, each rising edge of the group input that is held high for at least two cycles gives exactly one single-cycle tick. The tick appears three clock edges after the input changes.
- R8: In external mode, and in divider mode whenever the ratio (P+1)·2^(k+DIV_BASE) is at least 2, no tick pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_scale_i | input | 32 | Prescaler settings: group 0 in [7:0], group 1 in [15:8] |
| cfg_route_i | input | 32 | Per-channel 4-bit source/divider codes at bit 4·channel |
| ext_tick_i | input | 2 | Asynchronous external tick inputs, one per channel group |
| tick_en_o | output | 5 | One-cycle tick-enable strobes, one per channel |

## Verification
The hardest situation to reach is a prescaler setting that changes in the middle of a prescaler period. The write has to land a fixed number of cycles after a wrap for the deferred load to show. The stimulus achieves this by waiting for a channel tick, which is itself aligned to a wrap, and rewriting the setting at the very next sampling point. It then measures the two intervals that follow. The sweep over settings, codes and channels keeps the other group's prescaler and the other channels' codes at different values. A wrong field slice or group mapping therefore shows up as a wrong tick spacing.

// File: rtl/pts_pkg.sv
package pts_pkg;

    typedef enum logic [0:0] {
        SRC_DIVIDE   = 1'b0,
        SRC_EXTERNAL = 1'b1
    } src_state_t;

    // Channels below the split point belong to group 0, the rest to group 1.
    function automatic int unsigned group_of(input int unsigned ch, input int unsigned split);
        return (ch < split) ? 0 : 1;
    endfunction

endpackage

// File: rtl/pts_prescaler.sv
module pts_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] reload_i,
    output logic             wrap_o
);

    logic [PRE_W-1:0] count_q;
    logic [PRE_W-1:0] limit_q;

    assign wrap_o = (count_q == limit_q);

    // The limit is sampled only at a wrap, so a period in progress is never cut short.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            limit_q <= '0;
        end else if (wrap_o) begin
            count_q <= '0;
            limit_q <= reload_i;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // R3: the count never passes the active limit
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= limit_q);

    // R5: the active limit only moves right after a wrap
    a_r5_reload_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_q != $past(limit_q)) |-> $past(wrap_o));

endmodule

// File: rtl/pts_edge_sync.sv
module pts_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~hist_q;

    // R7: a detected edge is a single-cycle event
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pts_chan_sel.sv
module pts_chan_sel
    import pts_pkg::*;
#(
    parameter int unsigned MUX_W    = 4,
    parameter int unsigned DIV_BASE = 1,
    parameter logic [(1<<MUX_W)-1:0] EXT_MASK = 16'h0010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MUX_W-1:0] code_i,
    input  logic             presc_tick_i,
    input  logic             ext_rise_i,
    output logic             tick_o
);

    localparam int unsigned NUM_CODES = 1 << MUX_W;
    localparam int unsigned CNT_W     = NUM_CODES - 1 + DIV_BASE;
    localparam int unsigned EXP_W     = $clog2(CNT_W + 1);

    src_state_t       state_q;
    src_state_t       state_d;
    logic [MUX_W-1:0] code_q;
    logic [CNT_W-1:0] div_cnt_q;
    logic [CNT_W-1:0] div_mask;
    logic [EXP_W-1:0] exponent;
    logic             restart;
    logic             code_is_ext;
    logic             tick_d;

    assign code_is_ext = EXT_MASK[code_i];
    assign exponent    = EXP_W'(code_i) + EXP_W'(DIV_BASE);
    assign div_mask    = {CNT_W{1'b1}} >> (CNT_W - exponent);
    assign restart     = (code_i != code_q);

    // Source selection: transitions follow the mask membership of the code.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_DIVIDE:   if (code_is_ext)  state_d = SRC_EXTERNAL;
            SRC_EXTERNAL: if (!code_is_ext) state_d = SRC_DIVIDE;
            default:      state_d = SRC_DIVIDE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_DIVIDE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_i;
        end
    end

    // Output decision per state.
    always_comb begin
        tick_d = 1'b0;
        unique case (state_q)
            SRC_DIVIDE:   tick_d = presc_tick_i && ((div_cnt_q & div_mask) == div_mask);
            SRC_EXTERNAL: tick_d = ext_rise_i;
            default:      tick_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt_q <= '0;
            tick_o    <= 1'b0;
        end else begin
            tick_o <= tick_d;
            if (restart) begin
                div_cnt_q <= '0;
            end else if ((state_q == SRC_DIVIDE) && presc_tick_i) begin
                div_cnt_q <= div_cnt_q + 1'b1;
            end
        end
    end

    // R3: a divider-mode tick always follows a prescaler wrap
    a_r3_div_tick_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(state_q == SRC_DIVIDE)) |-> $past(presc_tick_i));

    // R6: an external-mode tick always follows a synchronized edge
    a_r6_ext_tick_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(state_q == SRC_EXTERNAL)) |-> $past(ext_rise_i));

    // R8: in external mode pulses are one cycle wide
    a_r8_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(state_q == SRC_EXTERNAL) && (state_q == SRC_EXTERNAL)) |=> !tick_o);

endmodule

// File: rtl/pwm_tick_source.sv
module pwm_tick_source
    import pts_pkg::*;
#(
    parameter int unsigned NUM_CH    = 5,
    parameter int unsigned NUM_GRP   = 2,
    parameter int unsigned GRP_SPLIT = 2,
    parameter int unsigned PRE_W     = 8,
    parameter int unsigned MUX_W     = 4,
    parameter int unsigned DIV_BASE  = 1,
    parameter logic [(1<<MUX_W)-1:0] EXT_MASK = 16'h0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        cfg_scale_i,
    input  logic [31:0]        cfg_route_i,
    input  logic [NUM_GRP-1:0] ext_tick_i,
    output logic [NUM_CH-1:0]  tick_en_o
);

    localparam int unsigned SCALE_BITS = NUM_GRP * PRE_W;
    localparam int unsigned ROUTE_BITS = NUM_CH * MUX_W;

    logic [NUM_GRP-1:0] presc_wrap;
    logic [NUM_GRP-1:0] ext_rise;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_scale_i[31:SCALE_BITS], cfg_route_i[31:ROUTE_BITS]};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_group
        pts_prescaler #(
            .PRE_W (PRE_W)
        ) presc_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload_i (cfg_scale_i[g*PRE_W +: PRE_W]),
            .wrap_o   (presc_wrap[g])
        );

        pts_edge_sync sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ext_tick_i[g]),
            .rise_o  (ext_rise[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam int unsigned GRP = group_of(c, GRP_SPLIT);

        pts_chan_sel #(
            .MUX_W    (MUX_W),
            .DIV_BASE (DIV_BASE),
            .EXT_MASK (EXT_MASK)
        ) chan_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .code_i       (cfg_route_i[c*MUX_W +: MUX_W]),
            .presc_tick_i (presc_wrap[GRP]),
            .ext_rise_i   (ext_rise[GRP]),
            .tick_o       (tick_en_o[c])
        );
    end

    // R1: nothing ticks in the first cycle after reset is released
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> (tick_en_o == '0));

endmodule

// File: tb/pwm_tick_source_tb_top.sv
module pwm_tick_source_tb_top;

    localparam int DIVB = 1;
    localparam int LIM  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_scale_i = '0;
    logic [31:0] cfg_route_i = '0;
    logic [1:0]  ext_tick_i = '0;
    logic [4:0]  tick_en_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pwm_tick_source dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_scale_i (cfg_scale_i),
        .cfg_route_i (cfg_route_i),
        .ext_tick_i  (ext_tick_i),
        .tick_en_o   (tick_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Waits for a tick on ch (or uses the current one), then counts cycles to the next.
    task automatic measure(input int ch, output int iv);
        int n = 0;
        while (!tick_en_o[ch] && n < LIM) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        n = 1;
        while (!tick_en_o[ch] && n < LIM) begin
            @(negedge clk);
            n++;
        end
        iv = n;
    endtask

    function automatic int grp(input int ch);
        return (ch < 2) ? 0 : 1;
    endfunction

    // Drives five pulses on input gi, observes channel ch.
    task automatic ext_burst(input int ch, input int gi, output int cnt, output int maxrun, output int first);
        int run = 0;
        cnt = 0;
        maxrun = 0;
        first = -1;
        for (int t = 0; t < 36; t++) begin
            @(negedge clk);
            if (tick_en_o[ch]) begin
                cnt++;
                run++;
                if (first < 0) first = t;
            end else begin
                run = 0;
            end
            if (run > maxrun) maxrun = run;
            ext_tick_i[gi] = (t < 30) && ((t % 6) < 3);
        end
        ext_tick_i = '0;
    endtask

    initial begin
        int iv;
        int plist [5] = '{0, 1, 2, 5, 12};

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tick_en_o == 5'b0, "R1 reset", int'(tick_en_o), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3, R4: sweep channels, prescaler settings and codes
        for (int ch = 0; ch < 5; ch++) begin
            for (int pi = 0; pi < 5; pi++) begin
                for (int k = 0; k < 4; k++) begin
                    int p = plist[pi];
                    int other = p + 3;
                    logic [31:0] route = '0;
                    for (int c = 0; c < 5; c++) begin
                        route[c*4 +: 4] = (c == ch) ? 4'(k) : 4'((k + 1 + c) % 4);
                    end
                    cfg_route_i = route;
                    cfg_scale_i = (grp(ch) == 0) ? {16'h0, 8'(other), 8'(p)}
                                                 : {16'h0, 8'(p), 8'(other)};
                    measure(ch, iv);
                    measure(ch, iv);
                    check(iv == ((p + 1) << (k + DIVB)),
                          $sformatf("R3 R2 R4 ch%0d P%0d code%0d", ch, p, k),
                          iv, (p + 1) << (k + DIVB));
                end
            end
        end

        // R3: largest prescaler setting
        cfg_route_i = 32'h0000_3000;
        cfg_scale_i = 32'h0000_FF00;
        measure(3, iv);
        measure(3, iv);
        check(iv == 4096, "R3 P255 code3", iv, 4096);

        // R5: prescaler change in mid-period is deferred to the wrap
        cfg_route_i = 32'h0000_0000;
        cfg_scale_i = 32'h0000_0009;
        measure(0, iv);
        measure(0, iv);
        cfg_scale_i = 32'h0000_0002;
        measure(0, iv);
        check(iv == 13, "R5 first interval after change", iv, 13);
        measure(0, iv);
        check(iv == 6, "R5 second interval after change", iv, 6);

        // R6, R7, R8: external source per channel
        cfg_scale_i = 32'h0;
        for (int ch = 0; ch < 5; ch++) begin
            int cnt, maxrun, first;
            logic [31:0] route = '0;
            route[ch*4 +: 4] = 4'd4;
            cfg_route_i = route;
            repeat (4) @(negedge clk);
            ext_burst(ch, grp(ch), cnt, maxrun, first);
            check(cnt == 5, $sformatf("R6 R7 ch%0d tick count", ch), cnt, 5);
            check(maxrun == 1, $sformatf("R8 ch%0d pulse width", ch), maxrun, 1);
            check(first == 3, $sformatf("R7 ch%0d latency", ch), first, 3);
            ext_burst(ch, 1 - grp(ch), cnt, maxrun, first);
            check(cnt == 0, $sformatf("R6 ch%0d other input ignored", ch), cnt, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule